// File: doc/BRIEF.md
# Sign-Skewer Projection Array with Extremum Tracking

This block projects a stream of spectral pixels onto a bank of random directions at once. Every component of every direction is limited to +1 or -1. One band sample of the current pixel is broadcast each accepted beat to all NSKEW processing lanes. Each lane also takes its own sign bit for that band. A lane forms its dot product by adding or subtracting the sample into a signed accumulator, so no multiplier is needed. When the pixel's last band arrives, the lane spends one extra cycle comparing the finished dot product against the smallest and largest values seen so far in the pass. When a value is a new extreme, the lane keeps it together with the pixel index that produced it.

Samples enter through a valid/ready stream. A beat is taken on every rising edge where `in_valid` and `in_ready` are both high. The source must hold its data steady while `in_valid` is high and `in_ready` is low. The block applies back-pressure for exactly one cycle after each pixel's last beat, which is the compare cycle; at all other times `in_ready` is high. A pass starts after reset or after a pulse on `clr`. The pass ends with a pixel whose last beat carries `in_final`. After that pixel's compare, `done` pulses for one cycle and the extremes it reports are the results of the whole pass.

Top module: `skewer_proj_array`

## Requirements
- R1: For skewer k, sign bit `in_sign[k]` = 0 adds the sample and 1 subtracts it. The samples are unsigned, and the dot product is the signed sum over the pixel's beats.
- R2: All lanes use the same sample on the same accepted beat. Each lane's result depends only on its own sign bits.
- R3: The first compare after reset or `clr` sets both the minimum and the maximum of every lane to that pixel's dot product and index, and sets `ext_valid` to 1.
- R4: A later dot product strictly greater than the stored maximum replaces it and its index. A later dot product strictly smaller than the stored minimum replaces it and its index. The reported minimum never exceeds the reported maximum.
- R5: A dot product equal to a stored extreme leaves that extreme and its earlier index unchanged.
- R6: A beat is accepted when `in_valid` and `in_ready` are both high. After a beat with `in_last` is accepted, `in_ready` is low for exactly one cycle and then high again.
- R7: The updated extremes are visible one cycle after the compare cycle. In that same cycle `done` is high for a single cycle, and only if the pixel's last beat carried `in_final`.
- R8: `clr` drops `ext_valid`, discards any partly accumulated pixel, and makes the next beat start a new pixel.
- R9: The accumulator has SAMPLE_W + clog2(NBANDS) + 1 bits. NBANDS samples of the largest value give exactly +NBANDS·(2^SAMPLE_W−1) or −NBANDS·(2^SAMPLE_W−1) with no wrap.
- R10: Cycles with `in_valid` low between beats leave the accumulation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Starts a new pass: drops extremes and any partial pixel |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_sample | input | SAMPLE_W | Unsigned band sample, broadcast to all lanes |
| in_sign | input | NSKEW | Per-lane sign for this band, 1 = subtract |
| in_last | input | 1 | Marks the last band of a pixel |
| in_final | input | 1 | With in_last, marks the last pixel of the pass |
| in_pix | input | IDX_W | Pixel index, sampled on the last beat |
| ext_valid | output | 1 | Extremes hold at least one pixel's result |
| min_val | output | NSKEW·ACC_W | Per-lane signed minimum, lane k at bits k·ACC_W upward |
| min_idx | output | NSKEW·IDX_W | Pixel index of each lane's minimum |
| max_val | output | NSKEW·ACC_W | Per-lane signed maximum |
| max_idx | output | NSKEW·IDX_W | Pixel index of each lane's maximum |
| done | output | 1 | One-cycle pulse after the final pixel's compare |

## Verification
The hardest situations to reach from the ports are exact ties and `clr` arriving in the middle of a pixel. A tie needs two pixels whose whole band sequences give equal sums in every lane. The stimulus gets one by sending the same generated sample and sign sequence under two different pixel indices, and then checks that the earlier index survives in both the minimum and the maximum. For the mid-pixel case, the bench stops a pixel after a few beats and pulses `clr`. It then sends a complete pixel and checks that pixel's sums alone, which shows the abandoned beats left no residue.

// File: rtl/skp_pkg.sv
package skp_pkg;

  typedef enum logic {
    ST_ACC = 1'b0,
    ST_CMP = 1'b1
  } skp_state_e;

  function automatic int acc_width(input int sample_w, input int nbands);
    return sample_w + $clog2(nbands) + 1;
  endfunction

endpackage

// File: rtl/skp_ctrl.sv
module skp_ctrl #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             in_final,
  input  logic [IDX_W-1:0] in_pix,
  output logic             in_ready,
  output logic             beat,
  output logic             first_beat,
  output logic             cmp_en,
  output logic [IDX_W-1:0] cmp_idx,
  output logic             done
);
  import skp_pkg::*;

  skp_state_e       state_q;
  logic             fresh_q;
  logic             final_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign in_ready   = (state_q == ST_ACC);
  assign beat       = in_valid && in_ready;
  assign first_beat = fresh_q;
  assign cmp_en     = (state_q == ST_CMP);
  assign cmp_idx    = idx_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state_q <= ST_ACC;
      fresh_q <= 1'b1;
      final_q <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_CMP) && final_q;
      if (state_q == ST_CMP) begin
        state_q <= ST_ACC;
      end else if (beat) begin
        fresh_q <= in_last;
        if (in_last) begin
          state_q <= ST_CMP;
          idx_q   <= in_pix;
          final_q <= in_final;
        end
      end
    end
  end

  // R6: one stall cycle follows every accepted last beat
  a_r6_stall_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_last && !clr) |=> !in_ready);

  // R6: back-pressure never lasts longer than one cycle
  a_r6_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/skp_accum.sv
module skp_accum #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    first_beat,
  input  logic                    sign_neg,
  input  logic [SAMPLE_W-1:0]     sample,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] base;

  assign ext  = $signed({{(ACC_W-SAMPLE_W){1'b0}}, sample});
  assign base = first_beat ? '0 : acc_q;
  assign acc  = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (beat) begin
      acc_q <= sign_neg ? (base - ext) : (base + ext);
    end
  end

  // R10: without an accepted beat the sum holds
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(acc_q));

endmodule

// File: rtl/skp_extreme.sv
module skp_extreme #(
  parameter int ACC_W = 16,
  parameter int IDX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    cmp_en,
  input  logic signed [ACC_W-1:0] dot,
  input  logic [IDX_W-1:0]        idx,
  output logic                    have,
  output logic signed [ACC_W-1:0] min_v,
  output logic signed [ACC_W-1:0] max_v,
  output logic [IDX_W-1:0]        min_i,
  output logic [IDX_W-1:0]        max_i
);
  logic                    have_q;
  logic signed [ACC_W-1:0] min_q, max_q;
  logic [IDX_W-1:0]        mini_q, maxi_q;
  logic                    new_max, new_min;

  assign new_max = !have_q || (dot > max_q);
  assign new_min = !have_q || (dot < min_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      have_q <= 1'b0;
      min_q  <= '0;
      max_q  <= '0;
      mini_q <= '0;
      maxi_q <= '0;
    end else if (cmp_en) begin
      have_q <= 1'b1;
      if (new_max) begin
        max_q  <= dot;
        maxi_q <= idx;
      end
      if (new_min) begin
        min_q  <= dot;
        mini_q <= idx;
      end
    end
  end

  assign have  = have_q;
  assign min_v = min_q;
  assign max_v = max_q;
  assign min_i = mini_q;
  assign max_i = maxi_q;

  // R4: the pair stays ordered once filled
  a_r4_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    have_q |-> (min_q <= max_q));

  // R4: the maximum never falls within a pass
  a_r4_max_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && $past(have_q) && !$past(clr)) |-> (max_q >= $past(max_q)));

  // R8: clearing empties the tracker
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !have_q);

endmodule

// File: rtl/skewer_proj_array.sv
module skewer_proj_array #(
  parameter int SAMPLE_W = 12,
  parameter int NBANDS   = 8,
  parameter int NSKEW    = 4,
  parameter int IDX_W    = 8,
  localparam int ACC_W   = skp_pkg::acc_width(SAMPLE_W, NBANDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SAMPLE_W-1:0]    in_sample,
  input  logic [NSKEW-1:0]       in_sign,
  input  logic                   in_last,
  input  logic                   in_final,
  input  logic [IDX_W-1:0]       in_pix,
  output logic                   ext_valid,
  output logic [NSKEW*ACC_W-1:0] min_val,
  output logic [NSKEW*IDX_W-1:0] min_idx,
  output logic [NSKEW*ACC_W-1:0] max_val,
  output logic [NSKEW*IDX_W-1:0] max_idx,
  output logic                   done
);
  logic             beat, first_beat, cmp_en;
  logic [IDX_W-1:0] cmp_idx;
  logic [NSKEW-1:0] have_v;

  skp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_valid(in_valid), .in_last(in_last), .in_final(in_final), .in_pix(in_pix),
    .in_ready(in_ready), .beat(beat), .first_beat(first_beat),
    .cmp_en(cmp_en), .cmp_idx(cmp_idx), .done(done)
  );

  for (genvar k = 0; k < NSKEW; k++) begin : g_lane
    logic signed [ACC_W-1:0] dot;
    logic signed [ACC_W-1:0] lo, hi;

    skp_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first_beat(first_beat),
      .sign_neg(in_sign[k]), .sample(in_sample), .acc(dot)
    );

    skp_extreme #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_ext (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_en(cmp_en),
      .dot(dot), .idx(cmp_idx), .have(have_v[k]),
      .min_v(lo), .max_v(hi),
      .min_i(min_idx[k*IDX_W +: IDX_W]), .max_i(max_idx[k*IDX_W +: IDX_W])
    );

    assign min_val[k*ACC_W +: ACC_W] = lo;
    assign max_val[k*ACC_W +: ACC_W] = hi;
  end

  assign ext_valid = &have_v;

  // R7: done only ever follows a compare that filled the trackers
  a_r7_done_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ext_valid);

endmodule

// File: tb/sim_skewer_proj_array.sv
module sim_skewer_proj_array;
  localparam int CLK_P = 10;
  localparam int SW = 12;
  localparam int NB = 8;
  localparam int NS = 4;
  localparam int IW = 8;
  localparam int AW = SW + $clog2(NB) + 1;

  logic clk = 0, rst_n = 0, clr = 0;
  logic in_valid = 0, in_last = 0, in_final = 0;
  logic [SW-1:0] in_sample = '0;
  logic [NS-1:0] in_sign = '0;
  logic [IW-1:0] in_pix = '0;
  logic in_ready, ext_valid, done;
  logic [NS*AW-1:0] min_val, max_val;
  logic [NS*IW-1:0] min_idx, max_idx;

  int checks = 0, errors = 0;
  int e_min[NS], e_max[NS], e_mini[NS], e_maxi[NS];
  bit e_have = 0;

  always #(CLK_P/2) clk = ~clk;

  skewer_proj_array #(.SAMPLE_W(SW), .NBANDS(NB), .NSKEW(NS), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_sign(in_sign), .in_last(in_last), .in_final(in_final),
    .in_pix(in_pix), .ext_valid(ext_valid), .min_val(min_val), .min_idx(min_idx),
    .max_val(max_val), .max_idx(max_idx), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int samp(input int seed, input int b, input int mode);
    if (mode == 1) return (1 << SW) - 1;
    return (seed * 389 + b * 1237 + 17) % (1 << SW);
  endfunction

  function automatic bit sgn(input int seed, input int b, input int k, input int mode);
    if (mode == 1) return k[0];
    return 1'(((seed * 13 + b * 7 + k * 5) >> 2) & 1);
  endfunction

  task automatic check_ext(input string req);
    chk(req, int'(ext_valid), int'(e_have));
    for (int k = 0; k < NS; k++) begin
      chk(req, int'($signed(min_val[k*AW +: AW])), e_min[k]);
      chk(req, int'($signed(max_val[k*AW +: AW])), e_max[k]);
      chk(req, int'(min_idx[k*IW +: IW]), e_mini[k]);
      chk(req, int'(max_idx[k*IW +: IW]), e_maxi[k]);
    end
  endtask

  // drives one whole pixel, updates the model, and checks the handshake and results
  task automatic send_pixel(input int idx, input int seed, input bit fin,
                            input int gap, input int mode, input string req);
    int dot[NS];
    for (int k = 0; k < NS; k++) dot[k] = 0;
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      in_valid  = 1;
      in_sample = SW'(samp(seed, b, mode));
      for (int k = 0; k < NS; k++) begin
        in_sign[k] = sgn(seed, b, k, mode);
        dot[k] += in_sign[k] ? -samp(seed, b, mode) : samp(seed, b, mode);
      end
      in_last  = (b == NB - 1);
      in_final = fin && (b == NB - 1);
      in_pix   = IW'(idx);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (b != NB - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid  = 0;
          in_sample = '1;
          in_sign   = '1;
        end
      end
    end
    @(negedge clk);
    in_valid = 0;
    in_last  = 0;
    in_final = 0;
    chk("R6 stall after last", int'(in_ready), 0);
    for (int k = 0; k < NS; k++) begin
      if (!e_have) begin
        e_min[k] = dot[k]; e_max[k] = dot[k]; e_mini[k] = idx; e_maxi[k] = idx;
      end else begin
        if (dot[k] > e_max[k]) begin e_max[k] = dot[k]; e_maxi[k] = idx; end
        if (dot[k] < e_min[k]) begin e_min[k] = dot[k]; e_mini[k] = idx; end
      end
    end
    e_have = 1;
    @(negedge clk);
    chk("R6 ready back", int'(in_ready), 1);
    chk("R7 done", int'(done), int'(fin));
    check_ext(req);
    if (fin) begin
      @(negedge clk);
      chk("R7 done single", int'(done), 0);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 0;
    clr = 1;
    @(negedge clk);
    clr = 0;
    e_have = 0;
    for (int k = 0; k < NS; k++) begin
      e_min[k] = 0; e_max[k] = 0; e_mini[k] = 0; e_maxi[k] = 0;
    end
  endtask

  task automatic t_reset();
    chk("R8 reset ext_valid", int'(ext_valid), 0);
    chk("R7 reset done", int'(done), 0);
    chk("R6 reset ready", int'(in_ready), 1);
  endtask

  task automatic t_single();
    send_pixel(5, 1, 1, 0, 0, "R1 R3 first pixel");
  endtask

  task automatic t_multi();
    do_clear();
    for (int p = 0; p < 6; p++)
      send_pixel(20 + p, 7 + p * 3, p == 5, 0, 0, "R2 R4 multi pixel");
  endtask

  task automatic t_tie();
    do_clear();
    send_pixel(10, 3, 0, 0, 0, "R3 tie first");
    send_pixel(11, 3, 1, 0, 0, "R5 tie keeps earlier");
    for (int k = 0; k < NS; k++) begin
      chk("R5 min idx", int'(min_idx[k*IW +: IW]), 10);
      chk("R5 max idx", int'(max_idx[k*IW +: IW]), 10);
    end
  endtask

  task automatic t_bubbles();
    do_clear();
    send_pixel(30, 11, 0, 2, 0, "R10 bubbles");
    send_pixel(31, 12, 1, 1, 0, "R10 bubbles second");
  endtask

  task automatic t_wide();
    do_clear();
    send_pixel(40, 0, 1, 0, 1, "R9 full scale");
    chk("R9 positive", int'($signed(max_val[0 +: AW])), NB * ((1 << SW) - 1));
    chk("R9 negative", int'($signed(min_val[AW +: AW])), -NB * ((1 << SW) - 1));
  endtask

  task automatic t_clear_mid();
    send_pixel(50, 21, 0, 0, 0, "R4 before clear");
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      in_valid = 1; in_sample = 12'hABC; in_sign = '0; in_last = 0; in_pix = 8'd99;
      @(posedge clk);
    end
    do_clear();
    chk("R8 clear drops ext_valid", int'(ext_valid), 0);
    chk("R8 clear ready", int'(in_ready), 1);
    send_pixel(60, 5, 1, 0, 0, "R8 fresh after clear");
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_tie();
    t_bubbles();
    t_wide();
    t_clear_mid();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule